// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block sequences refresh for an asynchronous EDO DRAM controller. A free-running interval counter, derived from the clock frequency and the refresh interval, marks when a CAS-before-RAS refresh is owed. The block then asks the read/write arbiter for the pins with a request/acknowledge handshake. Once granted, it drives both byte-lane CAS strobes and RAS through a complete CBR cycle, including the precharge.

The block also runs self-refresh episodes. A self-refresh request from the system first starts a guard pass of interval-spaced CBR refreshes. After the pass, the block enters self-refresh by holding RAS low for at least the minimum self-refresh time. When the request drops, it leaves with the long self-refresh precharge and runs a second guard pass. The length of each guard pass depends on the normal-mode refresh policy. With distributed refresh it is one refresh. With RAS-only or burst refresh it is every row. A new episode is refused until every row has been refreshed since the last exit.

The row count (4096 or 1024) and the refresh interval are parameters. A phase output reports the episode state.

Top module: `dram_refresh_sched`

## Requirements
- R1: The interval is floor(REFI_NS × CLK_KHZ / 10^6) clock cycles. Outside self-refresh, a refresh becomes owed once per interval. At reset release and at each self-refresh exit, the interval counter starts from zero.
- R2: `ref_req` is raised only while no refresh sequence runs. Once raised, it stays high until `ref_ack` is sampled high with it. No pin moves before that grant.
- R3: A granted CBR cycle drives `cas_lo_n` and `cas_hi_n` low together while `ras_n` stays high for CSR cycles. Then `ras_n` is low for RAS cycles. Then all three are high for RP cycles. `ref_busy` is high from the cycle after the grant until the precharge ends.
- R4: A RAS-low period never lasts at least FORBID cycles and less than SR_MIN cycles.
- R5: `sr_req` high in phase 0 with re-entry allowed moves the block to phase 1. There, exactly N refreshes run at the interval, where N = ROWS when `guard_full` = 1 and N = 1 otherwise. The next grant then enters self-refresh, with CAS before RAS and RAS held low.
- R6: In self-refresh, RAS stays low for at least SR_MIN cycles. It rises on the first cycle at or after that minimum in which `sr_req` is low.
- R7: After a self-refresh exit, the RAS precharge lasts RPS cycles instead of RP.
- R8: After exit, the phase is 3. Exactly N refreshes (N as in R5) run at the interval, and then the phase returns to 0.
- R9: `sr_req` has no effect in phase 0 until ROWS refreshes have completed since the last exit. After reset, entry is allowed at once.
- R10: `phase` encodes 0 = idle, 1 = pre-entry pass, 2 = self-refresh (from the entry grant until RAS rises), and 3 = post-exit pass.
- R11: During reset, `ras_n`, `cas_lo_n` and `cas_hi_n` are high. `ref_req` and `ref_busy` are low, and `phase` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ack | input | 1 | Arbiter grants the pins to the refresh sequencer |
| sr_req | input | 1 | High asks for self-refresh, low asks to leave it |
| guard_full | input | 1 | 1: normal policy is RAS-only or burst, so guard passes cover all rows |
| ref_req | output | 1 | Refresh or self-refresh entry waiting for the pins |
| ref_busy | output | 1 | Sequencer owns RAS and CAS |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Low byte-lane column strobe, active low |
| cas_hi_n | output | 1 | High byte-lane column strobe, active low |
| phase | output | 2 | Episode state, encoded as in R10 |

## Verification
The assertions check the pin rules on every cycle: CAS leads every RAS fall, RAS-low lengths avoid the forbidden window, self-refresh holds last long enough, and the long precharge follows them. They also check that a pending request holds until granted and that a self-refresh exit leads straight into the post-exit phase. Only the bench's scenarios can show the counting behaviour: the interval spacing, the exact guard-pass lengths under both policies, and a blocked request staying ignored until enough rows have been refreshed since exit. The bench's cycle model also confirms the exact pin waveform against varying arbiter delays.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_SELF = 2'd2,
    PH_POST = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_CAS  = 3'd1,
    SQ_RAS  = 3'd2,
    SQ_HOLD = 3'd3,
    SQ_PRE  = 3'd4
  } seq_e;

  // whole cycles not exceeding the time span
  function automatic int cyc_floor(input longint ns, input longint khz);
    return int'((ns * khz) / 64'sd1000000);
  endfunction

  // whole cycles covering at least the time span
  function automatic int cyc_ceil(input longint ns, input longint khz);
    return int'((ns * khz + 64'sd999999) / 64'sd1000000);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refsch_tick.sv
module refsch_tick #(
  parameter int REFI_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int TW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(REFI_CYC - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;

  assign tick = !hold && (tcnt_q == T_LAST);

  always_comb begin
    tcnt_d = tcnt_q + 1'b1;
    if (hold || tick) tcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end

  generate
    if (REFI_CYC > 1) begin : g_gap
      // R1
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/refsch_cbr.sv
module refsch_cbr
  import refsch_pkg::*;
#(
  parameter int CSR_CYC    = 2,
  parameter int RAS_CYC    = 7,
  parameter int RP_CYC     = 4,
  parameter int RPS_CYC    = 12,
  parameter int SR_MIN_CYC = 12500,
  parameter int FORBID_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic to_self,
  input  logic sr_req,
  output logic seq_idle,
  output logic ras_n,
  output logic cas_n,
  output logic row_done,
  output logic sr_exit
);
  localparam int CMAX = imax(imax(SR_MIN_CYC, RPS_CYC), imax(RAS_CYC, imax(RP_CYC, CSR_CYC)));
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] RPS_LAST = CW'(RPS_CYC - 1);
  localparam logic [CW-1:0] SR_LAST  = CW'(SR_MIN_CYC - 1);

  seq_e          seq_q, seq_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          self_q, self_d;
  logic          long_q, long_d;
  logic [CW-1:0] pre_last;

  assign seq_idle = (seq_q == SQ_IDLE);
  assign ras_n    = !((seq_q == SQ_RAS) || (seq_q == SQ_HOLD));
  assign cas_n    = !(seq_q inside {SQ_CAS, SQ_RAS, SQ_HOLD});
  assign row_done = (seq_q == SQ_RAS) && (cnt_q == RAS_LAST);
  assign sr_exit  = (seq_q == SQ_HOLD) && (cnt_q >= SR_LAST) && !sr_req;
  assign pre_last = long_q ? RPS_LAST : RP_LAST;

  always_comb begin
    seq_d  = seq_q;
    cnt_d  = cnt_q + 1'b1;
    self_d = self_q;
    long_d = long_q;
    case (seq_q)
      SQ_IDLE: begin
        cnt_d = '0;
        if (start) begin
          seq_d  = SQ_CAS;
          self_d = to_self;
        end
      end
      SQ_CAS: if (cnt_q == CSR_LAST) begin
        seq_d = self_q ? SQ_HOLD : SQ_RAS;
        cnt_d = '0;
      end
      SQ_RAS: if (row_done) begin
        seq_d  = SQ_PRE;
        cnt_d  = '0;
        long_d = 1'b0;
      end
      SQ_HOLD: begin
        if (sr_exit) begin
          seq_d  = SQ_PRE;
          cnt_d  = '0;
          long_d = 1'b1;
        end else if (cnt_q >= SR_LAST) begin
          cnt_d = cnt_q;
        end
      end
      SQ_PRE: if (cnt_q == pre_last) begin
        seq_d = SQ_IDLE;
        cnt_d = '0;
      end
      default: begin
        seq_d = SQ_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      cnt_q  <= '0;
      self_q <= 1'b0;
      long_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      cnt_q  <= cnt_d;
      self_q <= self_d;
      long_q <= long_d;
    end
  end

  // pin-timing checker state
  localparam int LW = $clog2(imax(SR_MIN_CYC, RPS_CYC) + 2);
  localparam logic [LW-1:0] FORBID_L = LW'(FORBID_CYC);
  localparam logic [LW-1:0] SRMIN_L  = LW'(SR_MIN_CYC);
  localparam logic [LW-1:0] RPS_L    = LW'(RPS_CYC);

  logic [LW-1:0] lo_len, hi_len;
  logic          long_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len    <= '0;
      hi_len    <= '0;
      long_seen <= 1'b0;
    end else begin
      if (!ras_n) begin
        lo_len    <= (&lo_len) ? lo_len : lo_len + 1'b1;
        hi_len    <= '0;
        long_seen <= 1'b0;
      end else begin
        lo_len <= '0;
        hi_len <= (&hi_len) ? hi_len : hi_len + 1'b1;
        if (lo_len >= SRMIN_L) long_seen <= 1'b1;
      end
    end
  end

  // R3
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  // R4
  ras_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ((lo_len < FORBID_L) || (lo_len >= SRMIN_L)));

  // R6
  self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(seq_q == SQ_HOLD)) |-> (lo_len >= SRMIN_L));

  // R7
  long_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && long_seen) |-> (hi_len >= RPS_L));

endmodule

// File: rtl/refsch_mode.sv
module refsch_mode
  import refsch_pkg::*;
#(
  parameter int ROWS = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ref_ack,
  input  logic       sr_req,
  input  logic       guard_full,
  input  logic       seq_idle,
  input  logic       row_done,
  input  logic       sr_exit,
  output logic       ref_req,
  output logic       start,
  output logic       to_self,
  output logic [1:0] phase
);
  localparam int PW = $clog2(ROWS + 1);
  localparam logic [PW-1:0] ROWS_L = PW'(ROWS);
  localparam logic [PW-1:0] ONE_L  = PW'(1);

  phase_e        phase_q, phase_d;
  logic          owe_q, owe_d;
  logic          pend_q, pend_d;
  logic [PW-1:0] pass_q, pass_d;
  logic [PW-1:0] rows_q, rows_d;
  logic [PW-1:0] plen, pass_inc;

  assign plen     = guard_full ? ROWS_L : ONE_L;
  assign pass_inc = pass_q + 1'b1;
  assign ref_req  = seq_idle && (owe_q || pend_q);
  assign start    = ref_req && ref_ack;
  assign to_self  = pend_q;
  assign phase    = phase_q;

  always_comb begin
    owe_d   = tick || (owe_q && !start);
    phase_d = phase_q;
    pend_d  = pend_q;
    pass_d  = pass_q;
    rows_d  = rows_q;
    if (sr_exit) rows_d = '0;
    else if (row_done && (rows_q != ROWS_L)) rows_d = rows_q + 1'b1;
    case (phase_q)
      PH_IDLE: if (sr_req && (rows_q == ROWS_L)) begin
        phase_d = PH_PRE;
        pass_d  = '0;
      end
      PH_PRE: begin
        if (row_done) begin
          pass_d = pass_inc;
          if (pass_inc == plen) pend_d = 1'b1;
        end
        if (start && pend_q) begin
          phase_d = PH_SELF;
          pend_d  = 1'b0;
        end
      end
      PH_SELF: if (sr_exit) begin
        phase_d = PH_POST;
        pass_d  = '0;
      end
      PH_POST: if (row_done) begin
        pass_d = pass_inc;
        if (pass_inc == plen) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      owe_q   <= 1'b0;
      pend_q  <= 1'b0;
      pass_q  <= '0;
      rows_q  <= ROWS_L;
    end else begin
      phase_q <= phase_d;
      owe_q   <= owe_d;
      pend_q  <= pend_d;
      pass_q  <= pass_d;
      rows_q  <= rows_d;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  // R10
  self_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SELF) |=> ((phase_q == PH_SELF) || (phase_q == PH_POST)));

  // R8
  exit_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> (phase_q == PH_POST));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refsch_pkg::*;
#(
  parameter int CLK_KHZ   = 125000,
  parameter int REFI_NS   = 15600,
  parameter int ROWS      = 4096,
  parameter int SR_MIN_NS = 100000,
  parameter int FORBID_NS = 10000,
  parameter int CSR_NS    = 10,
  parameter int RAS_NS    = 50,
  parameter int RP_NS     = 30,
  parameter int RPS_NS    = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_ack,
  input  logic       sr_req,
  input  logic       guard_full,
  output logic       ref_req,
  output logic       ref_busy,
  output logic       ras_n,
  output logic       cas_lo_n,
  output logic       cas_hi_n,
  output logic [1:0] phase
);
  localparam int REFI_CYC   = cyc_floor(REFI_NS, CLK_KHZ);
  localparam int SR_MIN_CYC = cyc_ceil(SR_MIN_NS, CLK_KHZ);
  localparam int FORBID_CYC = cyc_ceil(FORBID_NS, CLK_KHZ);
  localparam int CSR_CYC    = cyc_ceil(CSR_NS, CLK_KHZ);
  localparam int RAS_CYC    = cyc_ceil(RAS_NS, CLK_KHZ);
  localparam int RP_CYC     = cyc_ceil(RP_NS, CLK_KHZ);
  localparam int RPS_CYC    = cyc_ceil(RPS_NS, CLK_KHZ);

  logic tick, seq_idle, row_done, sr_exit, start, to_self, cas_n;

  refsch_tick #(.REFI_CYC(REFI_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (phase == PH_SELF),
    .tick  (tick)
  );

  refsch_mode #(.ROWS(ROWS)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ref_ack    (ref_ack),
    .sr_req     (sr_req),
    .guard_full (guard_full),
    .seq_idle   (seq_idle),
    .row_done   (row_done),
    .sr_exit    (sr_exit),
    .ref_req    (ref_req),
    .start      (start),
    .to_self    (to_self),
    .phase      (phase)
  );

  refsch_cbr #(
    .CSR_CYC    (CSR_CYC),
    .RAS_CYC    (RAS_CYC),
    .RP_CYC     (RP_CYC),
    .RPS_CYC    (RPS_CYC),
    .SR_MIN_CYC (SR_MIN_CYC),
    .FORBID_CYC (FORBID_CYC)
  ) u_cbr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .to_self  (to_self),
    .sr_req   (sr_req),
    .seq_idle (seq_idle),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_done (row_done),
    .sr_exit  (sr_exit)
  );

  assign ref_busy = !seq_idle;
  assign cas_lo_n = cas_n;
  assign cas_hi_n = cas_n;

endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  // 125 MHz, interval 200 ns -> 25 cycles; 400 ns -> 50; 160 ns -> 20;
  // 10 ns -> 2; 50 ns -> 7; 30 ns -> 4; 90 ns -> 12
  localparam int REFI   = 25;
  localparam int ROWS   = 8;
  localparam int SRMIN  = 50;
  localparam int FORBID = 20;
  localparam int CSRC   = 2;
  localparam int RASC   = 7;
  localparam int RPC    = 4;
  localparam int RPSC   = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ref_ack, sr_req, guard_full;
  logic ref_req, ref_busy, ras_n, cas_lo_n, cas_hi_n;
  logic [1:0] phase;

  dram_refresh_sched #(
    .CLK_KHZ(125000), .REFI_NS(200), .ROWS(ROWS), .SR_MIN_NS(400),
    .FORBID_NS(160), .CSR_NS(10), .RAS_NS(50), .RP_NS(30), .RPS_NS(90)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .sr_req(sr_req),
    .guard_full(guard_full), .ref_req(ref_req), .ref_busy(ref_busy),
    .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .phase(phase)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: states 0 idle,1 cas,2 ras,3 hold,4 precharge
  int m_t, m_owe, m_st, m_c, m_ent, m_long, m_ph, m_pend, m_pass, m_rows;
  int tk, rq, ac, rd, ex, pl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_owe = 0; m_st = 0; m_c = 0; m_ent = 0; m_long = 0;
      m_ph = 0; m_pend = 0; m_pass = 0; m_rows = ROWS;
    end else begin
      pl = guard_full ? ROWS : 1;
      tk = (m_ph != 2 && m_t == REFI - 1) ? 1 : 0;
      rq = (m_st == 0 && (m_owe != 0 || m_pend != 0)) ? 1 : 0;
      ac = (rq != 0 && ref_ack) ? 1 : 0;
      rd = (m_st == 2 && m_c == RASC - 1) ? 1 : 0;
      ex = (m_st == 3 && m_c >= SRMIN - 1 && !sr_req) ? 1 : 0;
      m_t   = (m_ph == 2 || tk != 0) ? 0 : m_t + 1;
      m_owe = (tk != 0 || (m_owe != 0 && ac == 0)) ? 1 : 0;
      case (m_st)
        0: if (ac != 0) begin m_st = 1; m_c = 0; m_ent = m_pend; end
        1: if (m_c == CSRC - 1) begin m_st = (m_ent != 0) ? 3 : 2; m_c = 0; end
           else m_c++;
        2: if (rd != 0) begin m_st = 4; m_c = 0; m_long = 0; end else m_c++;
        3: if (ex != 0) begin m_st = 4; m_c = 0; m_long = 1; end
           else if (m_c < SRMIN - 1) m_c++;
        default: if (m_c == ((m_long != 0) ? RPSC : RPC) - 1) begin m_st = 0; m_c = 0; end
                 else m_c++;
      endcase
      case (m_ph)
        0: if (sr_req && m_rows == ROWS) begin m_ph = 1; m_pass = 0; end
        1: begin
          if (rd != 0) begin m_pass++; if (m_pass == pl) m_pend = 1; end
          if (ac != 0 && m_pend != 0) begin m_ph = 2; m_pend = 0; end
        end
        2: if (ex != 0) begin m_ph = 3; m_pass = 0; end
        default: if (rd != 0) begin m_pass++; if (m_pass == pl) m_ph = 0; end
      endcase
      if (ex != 0) m_rows = 0;
      else if (rd != 0 && m_rows < ROWS) m_rows++;
    end
  end

  // compare, measure and arbiter at the falling edge
  int ack_dly = 0, wcnt = 0;
  int lo = 0, hi = 0, cas_run = 0, pre_cnt = 0, post_cnt = 0;
  int prev_ph = 0, cyc = 0, last_rise = -1;
  bit prev_ras = 1, prev_req = 0, long_prev = 0, track_gap = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ref_ack = 0; wcnt = 0; lo = 0; hi = 0; cas_run = 0; prev_ph = 0;
      prev_ras = 1; prev_req = 0; long_prev = 0;
    end else begin
      cyc++;
      check("R3 ras_n", ras_n, (m_st == 2 || m_st == 3) ? 0 : 1);
      check("R3 cas_lo_n", cas_lo_n, (m_st >= 1 && m_st <= 3) ? 0 : 1);
      check("R3 cas_hi_n", cas_hi_n, (m_st >= 1 && m_st <= 3) ? 0 : 1);
      check("R3 ref_busy", ref_busy, (m_st != 0) ? 1 : 0);
      check("R2 ref_req", ref_req, (m_st == 0 && (m_owe != 0 || m_pend != 0)) ? 1 : 0);
      check("R10 phase", phase, m_ph);
      // R1 interval spacing of requests
      if (track_gap && ref_req && !prev_req) begin
        if (last_rise >= 0) check("R1 request spacing", cyc - last_rise, REFI);
        last_rise = cyc;
      end
      if (!cas_lo_n && ras_n) cas_run++;
      else if (cas_lo_n) cas_run = 0;
      if (!ras_n) begin
        if (prev_ras) begin
          check("R3 cas lead cycles", cas_run, CSRC);
          if (long_prev) check("R7 long precharge", (hi >= RPSC) ? 1 : 0, 1);
          long_prev = 0;
          hi = 0;
        end
        lo++;
      end else begin
        if (!prev_ras) begin
          check("R4 ras low outside window", (lo < FORBID || lo >= SRMIN) ? 1 : 0, 1);
          if (prev_ph == 2) begin
            check("R6 self-refresh hold", (lo >= SRMIN) ? 1 : 0, 1);
            long_prev = 1;
          end
          if (prev_ph == 1) pre_cnt++;
          if (prev_ph == 3) post_cnt++;
          lo = 0;
        end
        hi++;
      end
      if (prev_ph == 0 && phase == 1) pre_cnt = 0;
      if (prev_ph == 1 && phase == 2) check("R5 pre-entry pass length", pre_cnt, guard_full ? ROWS : 1);
      if (prev_ph == 2 && phase == 3) post_cnt = 0;
      if (prev_ph == 3 && phase == 0) check("R8 post-exit pass length", post_cnt, guard_full ? ROWS : 1);
      prev_ph = phase;
      prev_ras = ras_n;
      prev_req = ref_req;
      if (ref_req) begin
        ref_ack = (wcnt >= ack_dly);
        wcnt++;
      end else begin
        ref_ack = 0;
        wcnt = 0;
      end
    end
  end

  task automatic wait_phase(input int p);
    while (phase != 2'(p)) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    rst_n = 0; sr_req = 0; guard_full = 0;
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R11 reset ras_n", ras_n, 1);
      check("R11 reset cas_lo_n", cas_lo_n, 1);
      check("R11 reset cas_hi_n", cas_hi_n, 1);
      check("R11 reset ref_req", ref_req, 0);
      check("R11 reset ref_busy", ref_busy, 0);
      check("R11 reset phase", phase, 0);
    end
    @(negedge clk) rst_n = 1;
    // normal distributed refresh under two arbiter delays
    track_gap = 1; ack_dly = 0;
    repeat (90) @(negedge clk);
    ack_dly = 3;
    repeat (90) @(negedge clk);
    track_gap = 0; ack_dly = 1;
    // distributed policy: one guard refresh each side
    sr_req = 1;
    wait_phase(2);
    repeat (80) @(negedge clk);
    sr_req = 0;
    wait_phase(3);
    wait_phase(0);
    sr_req = 1;
    repeat (100) @(negedge clk);
    check("R9 blocked request ignored", phase, 0);
    wait_phase(2);
    sr_req = 0;
    wait_phase(0);
    // full-array guard passes
    repeat (10) @(negedge clk);
    guard_full = 1; ack_dly = 2;
    sr_req = 1;
    wait_phase(2);
    repeat (10) @(negedge clk);
    sr_req = 0;
    wait_phase(0);
    sr_req = 1;
    repeat (2) @(negedge clk);
    check("R9 entry allowed after full pass", phase, 1);
    wait_phase(2);
    sr_req = 0;
    wait_phase(0);
    repeat (30) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 R8 actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule